// File: doc/BRIEF.md
# SPD Bank and Write-Protect Controller

This block sits behind a two-wire serial slave and owns the state of a 4-Kb serial-presence EEPROM: which of the two 2-Kb banks is visible, and which of the four 1-Kb blocks are locked against writes. The slave front end reports START, STOP, every byte the host writes, and every request for a read byte. The controller decides whether each byte is acknowledged. It runs the bank and protection commands that are coded into the address byte itself, and it drives the memory-side traffic: word-address tracking, a 16-byte page buffer, the timed internal write cycle and reads from the current bank.

Protection commands are deliberately awkward to trigger. The host must hold a high-voltage flag on one address pin for the whole three-byte sequence, or the third byte is refused and nothing changes. The cell array is modelled by a plain synchronous memory. The write-cycle length is a parameter. Its default matches 5 ms at 250 MHz.

Top module: `spd_bank_wp_ctrl`

## Requirements
- R1: After reset the visible bank is 0, no block is protected, the write cycle is idle and `ack_o` is low.
- R2: Address byte 0x6C selects bank 0 and 0x6E selects bank 1. Both are acknowledged, and `bank_o` takes the new value in the same cycle as `ack_o`. Later bytes of that transaction are not acknowledged.
- R3: Address byte 0x6D (bank query) is acknowledged when bank 0 is visible and not acknowledged when bank 1 is visible.
- R4: Address bytes 0x62, 0x68, 0x6A and 0x60 set protection on blocks 0, 1, 2 and 3, and 0x66 clears all four. The address byte and the second byte are acknowledged. If `hv_i` is high at all three bytes, the third byte is acknowledged and `wp_o` changes in that cycle; bit n of `wp_o` stands for block n.
- R5: If `hv_i` is low at any of the three bytes of a set or clear command, the third byte is not acknowledged and `wp_o` is unchanged.
- R6: Address bytes 0x63, 0x69, 0x6B and 0x61 query blocks 0, 1, 2 and 3. Each is acknowledged when its block is unprotected and refused when it is protected.
- R7: Address byte 1010 followed by `dev_sel_i` and the R/W bit (R/W=1 for read) is acknowledged. In write mode the next byte sets the word pointer. Each read request returns the byte at the pointer in the visible bank, one cycle later on `rd_data_o`, and the pointer then advances over the whole 256-byte bank.
- R8: Data bytes after the word address are acknowledged and buffered from the pointer upward. The increment touches only the low four pointer bits, so the bytes wrap inside the 16-byte page. The buffer goes to the array only at STOP. A START before STOP discards it.
- R9: A STOP that ends a buffered write raises `busy_o` for exactly `max(WRITE_CYCLES,16)` cycles. No address byte of any kind is acknowledged while `busy_o` is high.
- R10: Bytes written into a protected block are acknowledged but not stored, and they start no write cycle. The block index is the top two bits of the 9-bit array address.
- R11: The array address is the bank bit followed by the 8-bit word address. Switching banks leaves `wp_o` unchanged.
- R12: Any other address byte is refused: preamble 0011, a 1010 byte whose select bits do not match `dev_sel_i`, or an unused 0110 code. So is every later byte of that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel_i | input | 3 | Strapped device select bits |
| hv_i | input | 1 | High voltage detected on the protect-enable pin |
| start_i | input | 1 | One-cycle pulse: START or repeated START seen |
| stop_i | input | 1 | One-cycle pulse: STOP seen |
| byte_valid_i | input | 1 | One-cycle pulse: a host-written byte is complete |
| byte_i | input | 8 | The byte that was received |
| rd_req_i | input | 1 | One-cycle pulse: slave needs the next read byte |
| ack_o | output | 1 | Acknowledge decision for the last received byte, valid the cycle after `byte_valid_i` |
| rd_data_o | output | 8 | Read byte, valid the cycle after `rd_req_i` |
| bank_o | output | 1 | Currently visible bank |
| wp_o | output | 4 | Per-block write-protect state |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
A wrong bank bit shows up the cycle after a bank query, as an inverted acknowledge. It also shows up on the next read, as data from the other half of the array. A corrupted protection bit shows up immediately in `wp_o`, and a status query gives the wrong acknowledge. The damage to stored data stays hidden until a later read-back, after the write cycle, returns the old byte or a byte that should never have been written. A page pointer that carries into the page bits, or a write cycle of the wrong length, is seen only after STOP: the first through misplaced bytes in a later read, the second through the number of cycles `busy_o` stays high.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam int NUM_BLK = 4;
    localparam int BLK_W   = 2;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_EE_WR,
        CMD_EE_RD,
        CMD_SET_WP,
        CMD_CLR_WP,
        CMD_QRY_WP,
        CMD_SEL_BANK,
        CMD_QRY_BANK
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_EE_WADDR,
        ST_EE_WDATA,
        ST_EE_READ,
        ST_PROT,
        ST_IGNORE
    } st_e;

endpackage

// File: rtl/spd_addr_decode.sv
module spd_addr_decode
    import spd_pkg::*;
(
    input  logic [7:0]       addr_byte_i,
    input  logic [2:0]       dev_sel_i,
    output cmd_e             cmd_o,
    output logic [BLK_W-1:0] blk_o,
    output logic             bank_o
);

    logic [3:0] pre;
    logic [2:0] sel;
    logic       rd;

    assign pre = addr_byte_i[7:4];
    assign sel = addr_byte_i[3:1];
    assign rd  = addr_byte_i[0];

    always_comb begin
        cmd_o  = CMD_NONE;
        blk_o  = '0;
        bank_o = 1'b0;
        if (pre == 4'hA) begin
            if (sel == dev_sel_i) begin
                cmd_o = rd ? CMD_EE_RD : CMD_EE_WR;
            end
        end else if (pre == 4'h6) begin
            case (sel)
                3'b001: begin blk_o = 2'd0; cmd_o = rd ? CMD_QRY_WP : CMD_SET_WP; end
                3'b100: begin blk_o = 2'd1; cmd_o = rd ? CMD_QRY_WP : CMD_SET_WP; end
                3'b101: begin blk_o = 2'd2; cmd_o = rd ? CMD_QRY_WP : CMD_SET_WP; end
                3'b000: begin blk_o = 2'd3; cmd_o = rd ? CMD_QRY_WP : CMD_SET_WP; end
                3'b011: cmd_o = rd ? CMD_NONE : CMD_CLR_WP;
                3'b110: cmd_o = rd ? CMD_QRY_BANK : CMD_SEL_BANK;
                3'b111: begin
                    cmd_o  = rd ? CMD_NONE : CMD_SEL_BANK;
                    bank_o = 1'b1;
                end
                default: cmd_o = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/spd_wp_bank.sv
module spd_wp_bank
    import spd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bank_en_i,
    input  logic               bank_val_i,
    input  logic               set_en_i,
    input  logic [BLK_W-1:0]   set_idx_i,
    input  logic               clr_en_i,
    output logic               bank_o,
    output logic [NUM_BLK-1:0] wp_o
);

    typedef struct packed {
        logic               bank;
        logic [NUM_BLK-1:0] wp;
    } wpb_t;

    wpb_t d, q;

    always_comb begin
        d = q;
        if (bank_en_i) d.bank = bank_val_i;
        if (clr_en_i)  d.wp = '0;
        else if (set_en_i) d.wp[set_idx_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bank_o = q.bank;
    assign wp_o   = q.wp;

    a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i && !clr_en_i |=> wp_o[$past(set_idx_i)]);

    a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> wp_o == '0);

endmodule

// File: rtl/spd_page_buf.sv
module spd_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [IDX_W-1:0]      rd_idx_i,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic [PAGE_BYTES-1:0] mask_o
);

    logic [PAGE_BYTES-1:0] hit;
    logic [PAGE_BYTES-1:0] mask_d, mask_q;
    logic [DATA_W-1:0]     data_d [PAGE_BYTES];
    logic [DATA_W-1:0]     data_q [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        assign hit[g] = wr_en_i && (wr_idx_i == IDX_W'(g));

        always_comb begin
            data_d[g] = hit[g] ? wr_data_i : data_q[g];
            if (clr_i)       mask_d[g] = 1'b0;
            else if (hit[g]) mask_d[g] = 1'b1;
            else             mask_d[g] = mask_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[g] <= '0;
                mask_q[g] <= 1'b0;
            end else begin
                data_q[g] <= data_d[g];
                mask_q[g] <= mask_d[g];
            end
        end
    end

    assign rd_data_o = data_q[rd_idx_i];
    assign mask_o    = mask_q;

    a_r8_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && !clr_i |=> mask_o[$past(wr_idx_i)]);

endmodule

// File: rtl/spd_array.sv
module spd_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells[waddr_i] <= wdata_i;
        if (re_i) rdata_o <= cells[raddr_i];
    end

endmodule

// File: rtl/spd_bank_wp_ctrl.sv
module spd_bank_wp_ctrl
    import spd_pkg::*;
#(
    parameter int WRITE_CYCLES = 1250000,
    parameter int PAGE_BYTES   = 16,
    parameter int WORD_W       = 8,
    parameter int DATA_W       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         dev_sel_i,
    input  logic               hv_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               byte_valid_i,
    input  logic [7:0]         byte_i,
    input  logic               rd_req_i,
    output logic               ack_o,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               bank_o,
    output logic [NUM_BLK-1:0] wp_o,
    output logic               busy_o
);

    localparam int ADDR_W   = WORD_W + 1;
    localparam int IDX_W    = $clog2(PAGE_BYTES);
    localparam int PAGE_W   = WORD_W - IDX_W;
    localparam int BUSY_LEN = (WRITE_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WRITE_CYCLES;
    localparam int CNT_W    = $clog2(BUSY_LEN + 1);

    typedef struct packed {
        st_e              st;
        logic [WORD_W-1:0] ptr;
        logic [PAGE_W-1:0] page;
        logic              third;
        logic              hv_ok;
        logic              p_clr;
        logic [BLK_W-1:0]  p_blk;
        logic              ack;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic              c_bank;
        logic [PAGE_W-1:0] c_page;
    } ctrl_t;

    ctrl_t d, q;

    cmd_e              dec_cmd;
    logic [BLK_W-1:0]  dec_blk;
    logic              dec_bank;

    logic              bank_en, bank_val, set_en, clr_en;
    logic [BLK_W-1:0]  set_idx;
    logic              buf_clr, buf_we;
    logic [DATA_W-1:0] buf_rdata;
    logic [PAGE_BYTES-1:0] buf_mask;
    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [ADDR_W-1:0] stop_addr;
    logic              stop_locked;

    spd_addr_decode u_dec (
        .addr_byte_i (byte_i),
        .dev_sel_i   (dev_sel_i),
        .cmd_o       (dec_cmd),
        .blk_o       (dec_blk),
        .bank_o      (dec_bank)
    );

    spd_wp_bank u_wpb (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_en_i  (bank_en),
        .bank_val_i (bank_val),
        .set_en_i   (set_en),
        .set_idx_i  (set_idx),
        .clr_en_i   (clr_en),
        .bank_o     (bank_o),
        .wp_o       (wp_o)
    );

    spd_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .wr_en_i   (buf_we),
        .wr_idx_i  (q.ptr[IDX_W-1:0]),
        .wr_data_i (byte_i[DATA_W-1:0]),
        .rd_idx_i  (q.cnt[IDX_W-1:0]),
        .rd_data_o (buf_rdata),
        .mask_o    (buf_mask)
    );

    spd_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (buf_rdata),
        .re_i    (mem_re),
        .raddr_i (mem_raddr),
        .rdata_o (rd_data_o)
    );

    assign stop_addr   = {bank_o, q.page, {IDX_W{1'b0}}};
    assign stop_locked = wp_o[stop_addr[ADDR_W-1 -: BLK_W]];
    assign mem_waddr   = {q.c_bank, q.c_page, q.cnt[IDX_W-1:0]};
    assign mem_raddr   = {bank_o, q.ptr};

    always_comb begin
        d        = q;
        bank_en  = 1'b0;
        bank_val = 1'b0;
        set_en   = 1'b0;
        set_idx  = q.p_blk;
        clr_en   = 1'b0;
        buf_clr  = 1'b0;
        buf_we   = 1'b0;
        mem_we   = 1'b0;
        mem_re   = 1'b0;

        // internal write cycle: drain buffer, then wait out the remainder
        if (q.busy) begin
            mem_we = (q.cnt < CNT_W'(PAGE_BYTES)) && buf_mask[q.cnt[IDX_W-1:0]];
            if (q.cnt == CNT_W'(BUSY_LEN - 1)) begin
                d.busy  = 1'b0;
                buf_clr = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (start_i) begin
            if (q.st == ST_EE_WDATA) buf_clr = 1'b1;
            d.st  = ST_ADDR;
            d.ack = 1'b0;
        end else if (stop_i) begin
            d.st = ST_IDLE;
            if (q.st == ST_EE_WDATA && (|buf_mask)) begin
                if (stop_locked) begin
                    buf_clr = 1'b1;
                end else begin
                    d.busy   = 1'b1;
                    d.cnt    = '0;
                    d.c_bank = bank_o;
                    d.c_page = q.page;
                end
            end
        end else if (byte_valid_i) begin
            d.ack = 1'b0;
            unique case (q.st)
                ST_ADDR: begin
                    d.st = ST_IGNORE;
                    if (!q.busy) begin
                        unique case (dec_cmd)
                            CMD_EE_WR: begin d.ack = 1'b1; d.st = ST_EE_WADDR; end
                            CMD_EE_RD: begin d.ack = 1'b1; d.st = ST_EE_READ; end
                            CMD_SEL_BANK: begin
                                d.ack    = 1'b1;
                                bank_en  = 1'b1;
                                bank_val = dec_bank;
                            end
                            CMD_QRY_BANK: d.ack = !bank_o;
                            CMD_QRY_WP:   d.ack = !wp_o[dec_blk];
                            CMD_SET_WP, CMD_CLR_WP: begin
                                d.ack   = 1'b1;
                                d.st    = ST_PROT;
                                d.third = 1'b0;
                                d.hv_ok = hv_i;
                                d.p_clr = (dec_cmd == CMD_CLR_WP);
                                d.p_blk = dec_blk;
                            end
                            default: d.ack = 1'b0;
                        endcase
                    end
                end
                ST_PROT: begin
                    if (!q.third) begin
                        d.ack   = 1'b1;
                        d.third = 1'b1;
                        d.hv_ok = q.hv_ok && hv_i;
                    end else begin
                        d.st = ST_IGNORE;
                        if (q.hv_ok && hv_i) begin
                            d.ack  = 1'b1;
                            clr_en = q.p_clr;
                            set_en = !q.p_clr;
                        end
                    end
                end
                ST_EE_WADDR: begin
                    d.ack   = 1'b1;
                    d.ptr   = byte_i[WORD_W-1:0];
                    d.page  = byte_i[WORD_W-1:IDX_W];
                    buf_clr = 1'b1;
                    d.st    = ST_EE_WDATA;
                end
                ST_EE_WDATA: begin
                    d.ack  = 1'b1;
                    buf_we = 1'b1;
                    d.ptr[IDX_W-1:0] = q.ptr[IDX_W-1:0] + 1'b1;
                end
                default: d.ack = 1'b0;
            endcase
        end

        if (rd_req_i && !start_i && !stop_i && q.st == ST_EE_READ) begin
            mem_re = 1'b1;
            d.ptr  = q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ack_o  = q.ack;
    assign busy_o = q.busy;

    a_r9_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && byte_valid_i && !start_i && !stop_i && q.st == ST_ADDR |=> !ack_o);

    a_r10_no_locked_store: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wp_o[mem_waddr[ADDR_W-1 -: BLK_W]]);

    a_r8_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_EE_WDATA && byte_valid_i && !start_i && !stop_i
        |=> q.ptr[WORD_W-1:IDX_W] == $past(q.ptr[WORD_W-1:IDX_W]));

    a_r5_wp_needs_hv: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wp_o) |-> $past(hv_i));

    a_r2_bank_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_o) |-> !$past(busy_o));

    a_r11_wp_bank_indep: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_o) |-> $stable(wp_o));

endmodule

// File: tb/test_spd_bank_wp_ctrl.sv
module test_spd_bank_wp_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dev_sel = 3'b101;
    logic       hv = 1'b0;
    logic       start = 1'b0, stop = 1'b0, bvalid = 1'b0, rd_req = 1'b0;
    logic [7:0] bdata = 8'h00;
    logic       ack_o, bank_o, busy_o;
    logic [7:0] rd_data_o;
    logic [3:0] wp_o;

    int total = 0;
    int bad   = 0;

    localparam logic [7:0] EE_W = 8'hAA;
    localparam logic [7:0] EE_R = 8'hAB;
    localparam int WCYC = 40;

    always #2 clk = ~clk;

    spd_bank_wp_ctrl #(.WRITE_CYCLES(WCYC)) i_spd_bank_wp_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_sel_i(dev_sel), .hv_i(hv),
        .start_i(start), .stop_i(stop), .byte_valid_i(bvalid), .byte_i(bdata),
        .rd_req_i(rd_req), .ack_o(ack_o), .rd_data_o(rd_data_o),
        .bank_o(bank_o), .wp_o(wp_o), .busy_o(busy_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic put(input logic [7:0] b, output logic a);
        @(negedge clk); bvalid = 1'b1; bdata = b;
        @(negedge clk); bvalid = 1'b0; a = ack_o;
    endtask

    task automatic get(output logic [7:0] v);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0; v = rd_data_o;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    // one-byte command; returns the address acknowledge
    task automatic cmd1(input logic [7:0] b, output logic a);
        do_start(); put(b, a); do_stop();
    endtask

    // three-byte protect command; hv pattern per byte, returns third ack
    task automatic prot(input logic [7:0] b, input logic [2:0] hvp, output logic a3);
        logic a;
        do_start();
        hv = hvp[0]; put(b, a);
        hv = hvp[1]; put(8'h00, a);
        hv = hvp[2]; put(8'h00, a3);
        hv = 1'b0;
        do_stop();
    endtask

    // write n bytes (low byte first) at word address; returns AND of acks
    task automatic ee_wr(input logic [7:0] wa, input logic [31:0] dat, input int n, output logic all_ack);
        logic a;
        do_start();
        put(EE_W, a); all_ack = a;
        put(wa, a);   all_ack &= a;
        for (int i = 0; i < n; i++) begin
            put(dat[8*i +: 8], a); all_ack &= a;
        end
        do_stop();
    endtask

    task automatic ee_rd1(input logic [7:0] wa, output logic [7:0] v);
        logic a;
        do_start(); put(EE_W, a); put(wa, a);
        do_start(); put(EE_R, a);
        get(v);
        do_stop();
    endtask

    task automatic t_reset();
        chk(bank_o == 1'b0, "R1 bank", bank_o, 0);
        chk(wp_o == 4'h0, "R1 wp", wp_o, 0);
        chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
        chk(ack_o == 1'b0, "R1 ack", ack_o, 0);
    endtask

    task automatic t_bank();
        logic a;
        do_start(); put(8'h6E, a);
        chk(a == 1'b1, "R2 select bank1 ack", a, 1);
        chk(bank_o == 1'b1, "R2 bank1", bank_o, 1);
        put(8'h00, a);
        chk(a == 1'b0, "R2 trailing byte nack", a, 0);
        do_stop();
        cmd1(8'h6D, a);
        chk(a == 1'b0, "R3 query in bank1", a, 0);
        cmd1(8'h6C, a);
        chk(bank_o == 1'b0 && a, "R2 bank0", bank_o, 0);
        cmd1(8'h6D, a);
        chk(a == 1'b1, "R3 query in bank0", a, 1);
    endtask

    task automatic t_ee_basic();
        logic ok, a;
        logic [7:0] v;
        int n;
        ee_wr(8'h10, 32'h00C3C2C1, 3, ok);
        chk(ok, "R7 write acks", ok, 1);
        chk(busy_o == 1'b1, "R9 busy after stop", busy_o, 1);
        cmd1(8'h69, a);
        chk(a == 1'b0, "R9 query refused while busy", a, 0);
        cmd1(EE_W, a);
        chk(a == 1'b0, "R9 own address refused while busy", a, 0);
        wait_idle();
        ee_wr(8'h20, 32'h000000AB, 1, ok);
        n = 0;
        while (busy_o) begin n++; @(negedge clk); end
        chk(n == WCYC, "R9 busy length", n, WCYC);
        do_start(); put(EE_W, a); put(8'h10, a);
        do_start(); put(EE_R, a);
        chk(a == 1'b1, "R7 read address ack", a, 1);
        for (int i = 0; i < 3; i++) begin
            get(v);
            chk(v == 8'hC1 + 8'(i), "R7 sequential read", v, 8'hC1 + i);
        end
        do_stop();
    endtask

    task automatic t_wrap();
        logic ok;
        logic [7:0] v;
        ee_wr(8'h1E, 32'hD4D3D2D1, 4, ok);
        wait_idle();
        ee_rd1(8'h1E, v); chk(v == 8'hD1, "R8 page byte 1E", v, 8'hD1);
        ee_rd1(8'h1F, v); chk(v == 8'hD2, "R8 page byte 1F", v, 8'hD2);
        ee_rd1(8'h10, v); chk(v == 8'hD3, "R8 wrapped to 10", v, 8'hD3);
        ee_rd1(8'h11, v); chk(v == 8'hD4, "R8 wrapped to 11", v, 8'hD4);
        ee_rd1(8'h12, v); chk(v == 8'hC3, "R8 untouched 12", v, 8'hC3);
        ee_rd1(8'h20, v); chk(v == 8'hAB, "R8 next page untouched", v, 8'hAB);
    endtask

    task automatic t_discard();
        logic ok, a;
        logic [7:0] v;
        ee_wr(8'h40, 32'h21, 1, ok);
        wait_idle();
        do_start(); put(EE_W, a); put(8'h40, a); put(8'h33, a);
        do_start(); do_stop();
        chk(busy_o == 1'b0, "R8 discarded write no cycle", busy_o, 0);
        ee_rd1(8'h40, v);
        chk(v == 8'h21, "R8 discarded write", v, 8'h21);
        ee_wr(8'h80, 32'h11, 1, ok);
        wait_idle();
    endtask

    task automatic t_protect();
        logic a;
        prot(8'h68, 3'b101, a);
        chk(a == 1'b0, "R5 hv dropped nack", a, 0);
        chk(wp_o == 4'h0, "R5 wp unchanged", wp_o, 0);
        prot(8'h6A, 3'b011, a);
        chk(a == 1'b0 && wp_o == 4'h0, "R5 hv late", wp_o, 0);
        prot(8'h68, 3'b111, a);
        chk(a == 1'b1 && wp_o == 4'b0010, "R4 set block1", wp_o, 4'b0010);
        prot(8'h6A, 3'b111, a);
        chk(wp_o == 4'b0110, "R4 set block2", wp_o, 4'b0110);
        cmd1(8'h63, a); chk(a == 1'b1, "R6 block0 free", a, 1);
        cmd1(8'h69, a); chk(a == 1'b0, "R6 block1 locked", a, 0);
        cmd1(8'h6B, a); chk(a == 1'b0, "R6 block2 locked", a, 0);
        cmd1(8'h61, a); chk(a == 1'b1, "R6 block3 free", a, 1);
    endtask

    task automatic t_locked_write();
        logic ok;
        logic [7:0] v;
        ee_wr(8'h80, 32'h55, 1, ok);
        chk(ok, "R10 locked write acked", ok, 1);
        chk(busy_o == 1'b0, "R10 no write cycle", busy_o, 0);
        ee_rd1(8'h80, v);
        chk(v == 8'h11, "R10 locked byte kept", v, 8'h11);
    endtask

    task automatic t_bank_mem();
        logic ok, a;
        logic [7:0] v;
        cmd1(8'h6E, a);
        chk(wp_o == 4'b0110, "R11 wp survives bank switch", wp_o, 4'b0110);
        ee_wr(8'h80, 32'h99, 1, ok);
        chk(busy_o == 1'b1, "R10 bank1 upper block writable", busy_o, 1);
        wait_idle();
        ee_rd1(8'h80, v);
        chk(v == 8'h99, "R11 bank1 byte 80", v, 8'h99);
        ee_wr(8'h10, 32'h77, 1, ok);
        chk(busy_o == 1'b0, "R10 bank1 lower block locked", busy_o, 0);
        cmd1(8'h6C, a);
        ee_rd1(8'h80, v);
        chk(v == 8'h11, "R11 bank0 byte 80 separate", v, 8'h11);
        prot(8'h66, 3'b111, a);
        chk(a == 1'b1 && wp_o == 4'h0, "R4 clear all", wp_o, 0);
    endtask

    task automatic t_foreign();
        logic a;
        do_start(); put(8'h30, a);
        chk(a == 1'b0, "R12 sensor preamble", a, 0);
        put(8'h00, a);
        chk(a == 1'b0, "R12 trailing byte", a, 0);
        do_stop();
        cmd1(8'hA0, a); chk(a == 1'b0, "R12 select mismatch", a, 0);
        cmd1(8'h64, a); chk(a == 1'b0, "R12 unused code", a, 0);
        cmd1(8'h6F, a); chk(a == 1'b0 && bank_o == 1'b0, "R12 unused read code", a, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank();
        t_ee_basic();
        t_wrap();
        t_discard();
        t_protect();
        t_locked_write();
        t_bank_mem();
        t_foreign();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule